// File: doc/BRIEF.md
# Double-Buffered Display Gamma Lookup Stage

This block is the colour gamma correction stage of a display output pipeline. Every incoming pixel carries red, green and blue codes. Each code indexes a lookup table with one entry per input code. The output channel takes its value from that channel's field of the indexed entry. When the stage is switched off, pixels pass through unchanged. The pixel path has one register stage in both cases.

A host fills the table through a word-addressed write window, with one 32-bit word per entry. Two table banks are kept. The host can update the table in two ways:

- **Off-then-rewrite.** The host switches the stage off and commits. It then polls the on/off readback until it reads off, and rewrites the table.
- **Shadow-bank swap.** The stage stays on and the host writes the shadow bank. It then commits a swap request. The swap happens at the next frame-start pulse, and the bank-index readback shows when it has completed.

Control writes only take effect after a commit strobe. Committed settings are then applied at a frame-start pulse, so a frame never mixes two settings.

The table depth is a build parameter. It must be 256 or 1024 entries, and any other value stops elaboration. Channel width is log2 of the depth.

Top module: `gamma_lut_db`

## Requirements
- R1: A table word holds blue in bits [BPC-1:0], green in [2*BPC-1:BPC] and red in [3*BPC-1:2*BPC], with BPC = log2(depth) (8 at the default 256). Each output channel is taken from its own field of the entry indexed by that channel's input code. Write-data bits above 3*BPC are ignored.
- R2: The table entry i is written at byte address 4*i of the table window. Address bits [1:0] are ignored.
- R3: pix_out_valid follows pix_in_valid after one clock. While the stage is off, pix_out_data equals the input of the previous cycle.
- R4: A control write sets only pending values. Control word bit 0 is enable and bit 1 is swap request. Without a cfg_done strobe, no frame-start pulse changes lut_on, buf_idx or the pixel output, and upd_busy stays low.
- R5: A committed enable is applied at the next frame_start pulse. It applies from the pixel presented in the same cycle as the pulse, and lut_on shows it after that edge.
- R6: While lut_on is 0, table writes go to the bank the pixel path will read, so enabling afterwards uses the freshly written table.
- R7: While lut_on is 1, table writes go to the other bank and do not change the output.
- R8: A committed swap request toggles buf_idx at the next frame_start pulse. The pixel presented with that pulse already uses the new bank.
- R9: upd_busy rises after a commit that carries a swap request. It clears by itself at the edge that performs the swap.
- R10: After reset, lut_on, upd_busy, buf_idx and pix_out_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_addr | input | log2(depth)+2 | Byte address in the table window |
| lut_wr_data | input | 32 | Packed table word |
| ctrl_wr_en | input | 1 | Control write strobe |
| ctrl_wr_data | input | 2 | Bit 0 enable, bit 1 swap request |
| cfg_done | input | 1 | Commit strobe for pending control |
| frame_start | input | 1 | Frame boundary pulse |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_data | input | 3*BPC | Input pixel {red, green, blue} |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_data | output | 3*BPC | Corrected pixel {red, green, blue} |
| lut_on | output | 1 | Stage currently in use (readback) |
| upd_busy | output | 1 | Swap committed and not yet performed |
| buf_idx | output | 1 | Bank the pixel path reads |

## Verification
Pixels are sent with the stage off, under a first table, under a second table after a swap, and under a third table rewritten through the off path. Each table gives different values per channel, so a wrong bank, a stale table or a swapped field shows up as a distinct mismatch.

Some pixels use equal codes in two channels and others use extreme codes. These show whether each channel indexes its own entry and takes its own field.

Frame-start pulses are given without a commit, and commits are given without a frame-start pulse. This separates pending, committed and active settings. The pixel presented with the swap pulse shows whether the new bank applies from the first pixel of the frame.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    // Control state of the stage: pending -> committed -> active.
    typedef struct packed {
        logic pend_en;
        logic pend_req;
        logic com_en;
        logic com_req;
        logic act_en;
        logic bank;
    } glut_ctrl_t;

    localparam glut_ctrl_t GLUT_CTRL_RST = '{default: 1'b0};

endpackage

// File: rtl/glut_ctrl.sv
module glut_ctrl
    import gamma_lut_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_en,
    input  logic [1:0] ctrl_wr_data,
    input  logic       cfg_done,
    input  logic       frame_start,
    output logic       act_en,
    output logic       bank,
    output logic       busy,
    output logic       eff_en,
    output logic       eff_bank,
    output logic       wr_bank
);

    glut_ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Frame boundary: committed settings become active.
        if (frame_start) begin
            st_d.act_en = st_q.com_en;
            if (st_q.com_req) begin
                st_d.bank    = ~st_q.bank;
                st_d.com_req = 1'b0;
            end
        end
        // Commit: pending settings become committed; request is consumed.
        if (cfg_done) begin
            st_d.com_en = st_q.pend_en;
            if (st_q.pend_req) begin
                st_d.com_req  = 1'b1;
                st_d.pend_req = 1'b0;
            end
        end
        // Host control write only touches pending values.
        if (ctrl_wr_en) begin
            st_d.pend_en  = ctrl_wr_data[0];
            st_d.pend_req = ctrl_wr_data[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GLUT_CTRL_RST;
        else        st_q <= st_d;
    end

    assign act_en   = st_q.act_en;
    assign bank     = st_q.bank;
    assign busy     = st_q.com_req;
    // Pixel presented with the frame pulse already sees the new settings.
    assign eff_en   = frame_start ? st_q.com_en : st_q.act_en;
    assign eff_bank = (frame_start && st_q.com_req) ? ~st_q.bank : st_q.bank;
    // Disabled: refill the bank that will be read; enabled: fill the shadow.
    assign wr_bank  = st_q.act_en ? ~st_q.bank : st_q.bank;

endmodule

// File: rtl/glut_bank.sv
module glut_bank #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 24,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_r,
    input  logic [IDX_W-1:0]  raddr_g,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [WORD_W-1:0] rword_r,
    output logic [WORD_W-1:0] rword_g,
    output logic [WORD_W-1:0] rword_b
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rword_r = mem_q[raddr_r];
    assign rword_g = mem_q[raddr_g];
    assign rword_b = mem_q[raddr_b];

endmodule

// File: rtl/glut_pix.sv
module glut_pix #(
    parameter int BPC = 8,
    localparam int PIX_W = 3 * BPC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    input  logic             eff_en,
    input  logic [PIX_W-1:0] word_r,
    input  logic [PIX_W-1:0] word_g,
    input  logic [PIX_W-1:0] word_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] dat;
    } pix_t;

    pix_t px_d, px_q;
    logic [PIX_W-1:0] mapped;

    assign mapped = {word_r[3*BPC-1:2*BPC], word_g[2*BPC-1:BPC], word_b[BPC-1:0]};

    always_comb begin
        px_d     = px_q;
        px_d.vld = in_valid;
        if (in_valid) px_d.dat = eff_en ? mapped : in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) px_q <= '0;
        else        px_q <= px_d;
    end

    assign out_valid = px_q.vld;
    assign out_data  = px_q.dat;

endmodule

// File: rtl/gamma_lut_db.sv
module gamma_lut_db #(
    parameter int LUT_DEPTH = 256,
    localparam int BPC    = $clog2(LUT_DEPTH),
    localparam int PIX_W  = 3 * BPC,
    localparam int LUT_AW = BPC + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lut_wr_en,
    input  logic [LUT_AW-1:0] lut_wr_addr,
    input  logic [31:0]       lut_wr_data,
    input  logic              ctrl_wr_en,
    input  logic [1:0]        ctrl_wr_data,
    input  logic              cfg_done,
    input  logic              frame_start,
    input  logic              pix_in_valid,
    input  logic [PIX_W-1:0]  pix_in_data,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out_data,
    output logic              lut_on,
    output logic              upd_busy,
    output logic              buf_idx
);

    generate
        if (LUT_DEPTH != 256 && LUT_DEPTH != 1024) begin : g_bad_depth
            $error("gamma_lut_db: LUT_DEPTH must be 256 or 1024");
        end
    endgenerate

    logic eff_en, eff_bank, wr_bank;
    logic [PIX_W-1:0] rw_r [2];
    logic [PIX_W-1:0] rw_g [2];
    logic [PIX_W-1:0] rw_b [2];
    logic unused_lsb;

    assign unused_lsb = ^{lut_wr_addr[1:0], lut_wr_data[31:PIX_W]};

    glut_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_en  (ctrl_wr_en),
        .ctrl_wr_data(ctrl_wr_data),
        .cfg_done    (cfg_done),
        .frame_start (frame_start),
        .act_en      (lut_on),
        .bank        (buf_idx),
        .busy        (upd_busy),
        .eff_en      (eff_en),
        .eff_bank    (eff_bank),
        .wr_bank     (wr_bank)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        glut_bank #(.DEPTH(LUT_DEPTH), .WORD_W(PIX_W)) bank_i (
            .clk    (clk),
            .we     (lut_wr_en && (wr_bank == b[0])),
            .waddr  (lut_wr_addr[LUT_AW-1:2]),
            .wdata  (lut_wr_data[PIX_W-1:0]),
            .raddr_r(pix_in_data[3*BPC-1:2*BPC]),
            .raddr_g(pix_in_data[2*BPC-1:BPC]),
            .raddr_b(pix_in_data[BPC-1:0]),
            .rword_r(rw_r[b]),
            .rword_g(rw_g[b]),
            .rword_b(rw_b[b])
        );
    end

    glut_pix #(.BPC(BPC)) pix_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (pix_in_valid),
        .in_data  (pix_in_data),
        .eff_en   (eff_en),
        .word_r   (rw_r[eff_bank]),
        .word_g   (rw_g[eff_bank]),
        .word_b   (rw_b[eff_bank]),
        .out_valid(pix_out_valid),
        .out_data (pix_out_data)
    );

endmodule

// File: rtl/glut_checker.sv
module glut_checker #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_done,
    input logic             frame_start,
    input logic             pix_in_valid,
    input logic [PIX_W-1:0] pix_in_data,
    input logic             pix_out_valid,
    input logic [PIX_W-1:0] pix_out_data,
    input logic             lut_on,
    input logic             upd_busy,
    input logic             buf_idx
);

    p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_in_valid |=> pix_out_valid);

    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_in_valid |=> !pix_out_valid);

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && !lut_on && !frame_start) |=> (pix_out_data == $past(pix_in_data)));

    p_busy_needs_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_busy) |-> $past(cfg_done));

    p_on_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(lut_on));

    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(buf_idx));

    p_swap_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && upd_busy && !cfg_done) |=> (!upd_busy && (buf_idx != $past(buf_idx))));

endmodule

bind gamma_lut_db glut_checker #(.PIX_W(PIX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_done     (cfg_done),
    .frame_start  (frame_start),
    .pix_in_valid (pix_in_valid),
    .pix_in_data  (pix_in_data),
    .pix_out_valid(pix_out_valid),
    .pix_out_data (pix_out_data),
    .lut_on       (lut_on),
    .upd_busy     (upd_busy),
    .buf_idx      (buf_idx)
);

// File: tb/gamma_lut_db_tb.sv
module gamma_lut_db_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lut_wr_en = 1'b0;
    logic [9:0]  lut_wr_addr = '0;
    logic [31:0] lut_wr_data = '0;
    logic        ctrl_wr_en = 1'b0;
    logic [1:0]  ctrl_wr_data = '0;
    logic        cfg_done = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_in_valid = 1'b0;
    logic [23:0] pix_in_data = '0;
    logic        pix_out_valid;
    logic [23:0] pix_out_data;
    logic        lut_on, upd_busy, buf_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gamma_lut_db dut_i (
        .clk(clk), .rst_n(rst_n),
        .lut_wr_en(lut_wr_en), .lut_wr_addr(lut_wr_addr), .lut_wr_data(lut_wr_data),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
        .cfg_done(cfg_done), .frame_start(frame_start),
        .pix_in_valid(pix_in_valid), .pix_in_data(pix_in_data),
        .pix_out_valid(pix_out_valid), .pix_out_data(pix_out_data),
        .lut_on(lut_on), .upd_busy(upd_busy), .buf_idx(buf_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Reference tables: distinct values per channel and per table.
    function automatic logic [23:0] tab(input int t, input int i);
        logic [7:0] x;
        x = i[7:0];
        case (t)
            0:       return {x ^ 8'h5A, ~x, x + 8'd3};
            1:       return {x + 8'd77, x ^ 8'hC3, 8'd255 - x};
            default: return {x, x >> 1, x << 1};
        endcase
    endfunction

    function automatic logic [23:0] mapx(input int t, input logic [23:0] p);
        logic [23:0] wr, wg, wb;
        wr = tab(t, int'(p[23:16]));
        wg = tab(t, int'(p[15:8]));
        wb = tab(t, int'(p[7:0]));
        return {wr[23:16], wg[15:8], wb[7:0]};
    endfunction

    task automatic load_table(input int t);
        for (int i = 0; i < 256; i++) begin
            lut_wr_en   = 1'b1;
            // R2: low address bits ignored on a few entries
            lut_wr_addr = 10'(i * 4) | ((i == 7) ? 10'd2 : (i == 200) ? 10'd3 : 10'd0);
            // R1: junk above bit 23 ignored
            lut_wr_data = {8'hA5, tab(t, i)};
            step();
        end
        lut_wr_en = 1'b0;
    endtask

    task automatic ctrl(input logic [1:0] v);
        ctrl_wr_en = 1'b1; ctrl_wr_data = v;
        step();
        ctrl_wr_en = 1'b0;
    endtask

    task automatic commit();
        cfg_done = 1'b1;
        step();
        cfg_done = 1'b0;
    endtask

    task automatic frame_idle();
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
    endtask

    // Send one pixel (optionally with frame pulse); output is checked after the edge.
    task automatic pix(input logic [23:0] p, input bit fs, input logic [23:0] exp, input string req);
        pix_in_valid = 1'b1; pix_in_data = p; frame_start = fs;
        step();
        pix_in_valid = 1'b0; frame_start = 1'b0;
        chk({req, " out_valid"}, 32'(pix_out_valid), 32'd1);
        chk({req, " out_data"}, 32'(pix_out_data), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R10 lut_on", 32'(lut_on), 0);
        chk("R10 upd_busy", 32'(upd_busy), 0);
        chk("R10 buf_idx", 32'(buf_idx), 0);
        chk("R10 out_valid", 32'(pix_out_valid), 0);
    endtask

    task automatic t_bypass();
        pix(24'h123456, 1'b0, 24'h123456, "R3 bypass");
        pix(24'hFF00A5, 1'b0, 24'hFF00A5, "R3 bypass");
        step();
        chk("R3 valid drops", 32'(pix_out_valid), 0);
    endtask

    task automatic t_legacy_load();
        load_table(0);                           // R6: off, so writes go to read bank
        pix(24'h070707, 1'b0, 24'h070707, "R3 bypass after load");
        ctrl(2'b01);
        frame_idle();                            // R4: no commit, no effect
        chk("R4 lut_on without commit", 32'(lut_on), 0);
        pix(24'h0A0B0C, 1'b1, 24'h0A0B0C, "R4 output without commit");
        commit();
        chk("R5 lut_on before frame", 32'(lut_on), 0);
        pix(24'h112233, 1'b0, 24'h112233, "R5 not yet applied");
        pix(24'h112233, 1'b1, mapx(0, 24'h112233), "R5 applied with frame pixel");
        chk("R5 lut_on after frame", 32'(lut_on), 1);
        pix(24'h000000, 1'b0, mapx(0, 24'h000000), "R1 zero codes");
        pix(24'hFF0080, 1'b0, mapx(0, 24'hFF0080), "R1 extreme codes");
        pix(24'h07C807, 1'b0, mapx(0, 24'h07C807), "R2 offset entries");
        chk("R8 buf_idx still 0", 32'(buf_idx), 0);
    endtask

    task automatic t_double_buffer();
        load_table(1);                           // R7: shadow bank
        pix(24'h112233, 1'b0, mapx(0, 24'h112233), "R7 shadow write unseen");
        ctrl(2'b11);
        chk("R9 busy before commit", 32'(upd_busy), 0);
        commit();
        chk("R9 busy after commit", 32'(upd_busy), 1);
        chk("R8 idx before frame", 32'(buf_idx), 0);
        pix(24'h5566AA, 1'b0, mapx(0, 24'h5566AA), "R8 old bank before frame");
        pix(24'h5566AA, 1'b1, mapx(1, 24'h5566AA), "R8 new bank with frame pixel");
        chk("R8 idx toggled", 32'(buf_idx), 1);
        chk("R9 busy self-clear", 32'(upd_busy), 0);
        chk("R5 still on", 32'(lut_on), 1);
        frame_idle();
        chk("R8 idx holds", 32'(buf_idx), 1);
        pix(24'hFF0080, 1'b0, mapx(1, 24'hFF0080), "R1 new table extremes");
    endtask

    task automatic t_legacy_rewrite();
        ctrl(2'b00);
        commit();
        chk("R5 still on before frame", 32'(lut_on), 1);
        frame_idle();
        chk("R5 off after frame", 32'(lut_on), 0);
        pix(24'h9A8B7C, 1'b0, 24'h9A8B7C, "R3 bypass after disable");
        load_table(2);                           // R6: goes to bank 1 (read bank)
        ctrl(2'b01);
        commit();
        frame_idle();
        chk("R6 buf_idx unchanged", 32'(buf_idx), 1);
        pix(24'h3C5A78, 1'b0, mapx(2, 24'h3C5A78), "R6 rewritten table used");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_bypass();
        t_legacy_load();
        t_double_buffer();
        t_legacy_rewrite();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule